// File: doc/BRIEF.md
# SPI Word Master

This block is a single-channel SPI master that moves one word per command. It runs on the system clock and makes the serial clock with a reloadable down-counter, so every half period of SCK lasts a whole number of system clocks. A command is a one-cycle start strobe. It carries two flags. One flag chooses the delay from chip-select to the first SCK edge. The other chooses the word length.

When a start is accepted, the block stores the divider, the clock phase and the resolved bit count. It then asserts chip-select and walks through five named states:

- ST_IDLE goes to ST_LEAD on an accepted start.
- ST_LEAD waits out the lead delay. It goes to ST_SHIFT on the first SCK edge.
- ST_SHIFT produces the remaining edges. It goes to ST_TRAIL on the last edge.
- ST_TRAIL holds chip-select for one more half period. It then goes to ST_FIN.
- ST_FIN is a single cycle. Chip-select is released and done is raised. It always returns to ST_IDLE.

Any start seen outside ST_IDLE, or while the divider is below 2, is dropped.

Top module: `spi_word_master`

## Requirements
- R1: Each SCK half period lasts `div_val` system clocks, so SCK runs at the system clock divided by 2·`div_val`. Legal values are 2 to 255. The value is captured when the start is accepted.
- R2: When `div_val` is 0 or 1, a start is ignored. `cs_n` stays 1, `done` stays 0 and `sck` stays at the `cpol` level.
- R3: SCK rests at `cpol` whenever `cs_n` is 1. The edges of a transfer are numbered from 1. With `cpha`=0, MOSI shows the MSB before edge 1, MISO is sampled on odd edges, and MOSI changes on even edges. With `cpha`=1, MOSI changes on odd edges after edge 1, and MISO is sampled on even edges.
- R4: With `dly_sel`=1, the first SCK edge comes `dly_val` system clocks after `cs_n` falls. A `dly_val` of 0 counts as 1.
- R5: With `dly_sel`=0, the first SCK edge comes `div_val` system clocks after `cs_n` falls, and `dly_val` has no effect.
- R6: With `len_sel`=0, a transfer is 8 bits and `len_val` has no effect.
- R7: With `len_sel`=1, the length is decoded from `len_val`. Code 0 gives 16 bits. Codes 8 to 15 give that many bits. Codes 1 to 7 give 8 bits.
- R8: Bits are shifted MSB first. The lower N bits of `tx_word` are sent. The received bits are right-justified in `rx_word`, and the bits above them are 0.
- R9: `cs_n` goes low in the cycle after an accepted start. It goes high again `div_val` clocks after the last SCK edge.
- R10: `done` is high for exactly one cycle, the first cycle in which `cs_n` is high again. `rx_word` holds the received word in that cycle.
- R11: A start during a transfer does not change its timing or its data.
- R12: During reset, `cs_n`=1, `done`=0, `sck`=`cpol` and `rx_word`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | DIV_W | SCK half-period in system clocks |
| dly_val | input | DLY_W | Programmed lead delay in system clocks |
| len_val | input | LEN_W | Programmed length code |
| cpol | input | 1 | SCK resting level |
| cpha | input | 1 | Clock phase select |
| start | input | 1 | One-cycle command strobe |
| dly_sel | input | 1 | Command flag: programmed lead delay |
| len_sel | input | 1 | Command flag: programmed length |
| tx_word | input | WORD_W | Word to send |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Chip-select, active low |
| rx_word | output | WORD_W | Received word, right-justified |
| done | output | 1 | End-of-transfer pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit divider, a 7-bit delay and a 16-bit word. With these values the bench can reach the divider's top value of 255, the longest lead delay of 127 and the full 16-bit length, as well as the reserved and zero length codes. Divider values of 2 to 5 keep most transfers short. This makes room for all four clock modes, both flag settings, a start strobe injected mid-transfer, and the disabled divider codes 0 and 1.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_FIN
    } xfer_state_t;
endpackage

// File: rtl/spi_len_sel.sv
// Resolves the per-command word length from the flag and the length code.
module spi_len_sel #(
    parameter int LEN_W    = 4,
    parameter int DEF_BITS = 8,
    parameter int MAX_BITS = 16,
    parameter int CW       = $clog2(MAX_BITS + 1)
) (
    input  logic             len_sel,
    input  logic [LEN_W-1:0] len_val,
    output logic [CW-1:0]    nbits
);
    always_comb begin
        if (!len_sel)
            nbits = CW'(DEF_BITS);
        else if (len_val == '0)
            nbits = CW'(MAX_BITS);      // R7: code 0 means the full word
        else if (int'(len_val) < DEF_BITS)
            nbits = CW'(DEF_BITS);      // R7: reserved codes fall back
        else
            nbits = CW'(len_val);
    end
endmodule

// File: rtl/spi_shifter.sv
// Transmit and receive shift registers, MSB first, receive right-justified.
module spi_shifter #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] nbits,
    input  logic [W-1:0]  tx_word,
    input  logic          shift_en,
    input  logic          sample_en,
    input  logic          miso,
    output logic          mosi,
    output logic [W-1:0]  rx_word
);
    logic [W-1:0] tx_sr;
    logic [W-1:0] rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= tx_word << (W - int'(nbits));
            rx_sr <= '0;
        end else begin
            if (shift_en)
                tx_sr <= {tx_sr[W-2:0], 1'b0};
            if (sample_en)
                rx_sr <= {rx_sr[W-2:0], miso};
        end
    end

    assign mosi    = tx_sr[W-1];
    assign rx_word = rx_sr;
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_word_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DLY_W    = 7,
    parameter int LEN_W    = 4,
    parameter int WORD_W   = 16,
    parameter int DEF_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [DLY_W-1:0]  dly_val,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              start,
    input  logic              dly_sel,
    input  logic              len_sel,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n,
    output logic [WORD_W-1:0] rx_word,
    output logic              done
);
    localparam int CW    = $clog2(WORD_W + 1);
    localparam int EW    = $clog2(2 * WORD_W + 1);
    localparam int CNT_W = (DIV_W > DLY_W) ? DIV_W : DLY_W;

    xfer_state_t       state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [EW-1:0]     edge_cnt;
    logic [EW-1:0]     next_edge;
    logic [DIV_W-1:0]  div_q;
    logic [CW-1:0]     nbits_q;
    logic [CW-1:0]     nbits_w;
    logic              cpha_q;
    logic              sck_q;
    logic              accept;
    logic              cnt_hit;
    logic              edge_go;
    logic              last_edge;
    logic              sample_en;
    logic              shift_en;
    logic [CNT_W-1:0]  lead_load;

    spi_len_sel #(
        .LEN_W(LEN_W), .DEF_BITS(DEF_BITS), .MAX_BITS(WORD_W), .CW(CW)
    ) u_len (
        .len_sel(len_sel), .len_val(len_val), .nbits(nbits_w)
    );

    assign accept    = (state == ST_IDLE) && start && (div_val >= DIV_W'(2));
    assign cnt_hit   = (cnt == CNT_W'(1));
    assign edge_go   = ((state == ST_LEAD) || (state == ST_SHIFT)) && cnt_hit;
    assign next_edge = edge_cnt + 1'b1;
    assign last_edge = (next_edge == EW'({nbits_q, 1'b0}));
    assign sample_en = edge_go && (next_edge[0] ^ cpha_q);
    assign shift_en  = edge_go && !(next_edge[0] ^ cpha_q) && (next_edge != EW'(1));
    assign lead_load = !dly_sel        ? CNT_W'(div_val) :
                       (dly_val == '0) ? CNT_W'(1)       : CNT_W'(dly_val);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)                state_nx = ST_LEAD;
            ST_LEAD:  if (cnt_hit)               state_nx = ST_SHIFT;
            ST_SHIFT: if (cnt_hit && last_edge)  state_nx = ST_TRAIL;
            ST_TRAIL: if (cnt_hit)               state_nx = ST_FIN;
            ST_FIN:                              state_nx = ST_IDLE;
            default:                             state_nx = ST_IDLE;
        endcase
    end

    // timing datapath: half-period counter, edge counter, captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            edge_cnt <= '0;
            div_q    <= '0;
            nbits_q  <= '0;
            cpha_q   <= 1'b0;
            sck_q    <= 1'b0;
        end else if (accept) begin
            div_q    <= div_val;
            nbits_q  <= nbits_w;
            cpha_q   <= cpha;
            cnt      <= lead_load;
            edge_cnt <= '0;
            sck_q    <= cpol;
        end else if ((state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL)) begin
            cnt <= cnt_hit ? CNT_W'(div_q) : cnt - 1'b1;
            if (edge_go) begin
                sck_q    <= ~sck_q;
                edge_cnt <= next_edge;
            end
        end
    end

    spi_shifter #(.W(WORD_W), .CW(CW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .nbits(nbits_w),
        .tx_word(tx_word), .shift_en(shift_en), .sample_en(sample_en),
        .miso(miso), .mosi(mosi), .rx_word(rx_word)
    );

    // outputs
    always_comb begin
        cs_n = !((state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL));
        done = (state == ST_FIN);
        sck  = ((state == ST_IDLE) || (state == ST_FIN)) ? cpol : sck_q;
    end
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [DIV_W-1:0] div_val,
    input logic             cpol,
    input logic             sck,
    input logic             cs_n,
    input logic             done
);
    p_rest_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cpol));

    p_disabled_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && start && (div_val < DIV_W'(2))) |=> (cs_n && !done));

    p_accept_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !done && start && (div_val >= DIV_W'(2))) |=> !cs_n);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));
endmodule

bind spi_word_master spi_word_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .div_val(div_val),
    .cpol(cpol), .sck(sck), .cs_n(cs_n), .done(done)
);

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_val = 8'd2;
    logic [6:0]  dly_val = '0;
    logic [3:0]  len_val = '0;
    logic        cpol = 1'b0, cpha = 1'b0, start = 1'b0;
    logic        dly_sel = 1'b0, len_sel = 1'b0;
    logic [15:0] tx_word = '0;
    logic        miso = 1'b0;
    logic        sck, mosi, cs_n, done;
    logic [15:0] rx_word;

    int checks = 0;
    int errors = 0;

    // slave model state
    bit          s_cpha = 1'b0;
    int          s_n = 8;
    logic [15:0] s_word = '0;
    logic [15:0] mosi_cap = '0;
    int          s_edges = 0;
    int          s_samples = 0;
    logic        s_prev = 1'b0;

    spi_word_master u0 (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .dly_val(dly_val),
        .len_val(len_val), .cpol(cpol), .cpha(cpha), .start(start),
        .dly_sel(dly_sel), .len_sel(len_sel), .tx_word(tx_word), .miso(miso),
        .sck(sck), .mosi(mosi), .cs_n(cs_n), .rx_word(rx_word), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural slave: counts SCK edges, captures MOSI, presents MISO
    always @(negedge clk) begin
        if (cs_n) begin
            s_edges   = 0;
            s_samples = 0;
            s_prev    = sck;
            mosi_cap  = '0;
        end else if (sck != s_prev) begin
            s_prev  = sck;
            s_edges = s_edges + 1;
            if ((s_edges % 2 == 1) == (s_cpha == 1'b0)) begin
                mosi_cap  = {mosi_cap[14:0], mosi};
                s_samples = s_samples + 1;
            end
        end
        miso = (s_samples < s_n) ? s_word[s_n - 1 - s_samples] : 1'b0;
    end

    // one transfer, compared against the expected waveform every cycle
    task automatic run_xfer(input int div, input int dly, input int len,
                            input bit pol, input bit pha, input bit dsel, input bit lsel,
                            input logic [15:0] tx, input logic [15:0] slv,
                            input bit poke, input string tag);
        int n, d, total, ed, mask;
        n = !lsel ? 8 : (len == 0) ? 16 : (len < 8) ? 8 : len;
        d = !dsel ? div : (dly == 0) ? 1 : dly;
        total = d + 2 * n * div;
        mask = (1 << n) - 1;
        @(negedge clk);
        div_val = 8'(div); dly_val = 7'(dly); len_val = 4'(len);
        cpol = pol; cpha = pha; dly_sel = dsel; len_sel = lsel; tx_word = tx;
        s_cpha = pha; s_n = n; s_word = slv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i <= total; i++) begin
            if (i > 0) @(negedge clk);
            ed = (i < d) ? 0 : ((i - d) / div + 1);
            if (ed > 2 * n) ed = 2 * n;
            chk(cs_n == (i == total), {tag, " cs_n"}, int'(cs_n), int'(i == total));
            chk(sck == (pol ^ ed[0]), {tag, " sck"}, int'(sck), int'(pol ^ ed[0]));
            chk(done == (i == total), {tag, " done R10"}, int'(done), int'(i == total));
            start = (poke && i == d + div) ? 1'b1 : 1'b0;   // R11 stray strobe
        end
        chk(rx_word == 16'(slv & mask), {tag, " rx_word R8"}, int'(rx_word), slv & mask);
        chk(mosi_cap == 16'(tx & mask), {tag, " mosi R8"}, int'(mosi_cap), tx & mask);
        @(negedge clk);
        chk(!done && cs_n, {tag, " quiet after done R10"}, int'(done), 0);
    endtask

    task automatic try_disabled(input int div, input bit pol);
        @(negedge clk);
        div_val = 8'(div); cpol = pol; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chk(cs_n && !done && (sck == pol), "R2 disabled divider", int'({cs_n, done, sck}), int'({1'b1, 1'b0, pol}));
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(cs_n && !done && sck == cpol && rx_word == 16'h0, "R12 reset", int'({cs_n, done, sck}), 4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 R3 R6: mode 0, standard delay, default length
        run_xfer(2, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C, 1'b0, "R1 R3 R6");
        // R4 R7: programmed delay 5, code 0 gives 16 bits, mode 1
        run_xfer(3, 5, 0, 1'b0, 1'b1, 1'b1, 1'b1, 16'hBEEF, 16'h1234, 1'b0, "R4 R7");
        // R4 delay code 0 counts as 1; R7 reserved code 3 gives 8 bits; R8 upper bits zero
        run_xfer(2, 0, 3, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0F0F, 16'hFF81, 1'b0, "R4 R7 R8");
        // R5 delay field ignored; R11 stray start; 12 bits, mode 3
        run_xfer(4, 50, 12, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0ABC, 16'h0F5A, 1'b1, "R5 R11");
        // R6 length code ignored when flag is 0
        run_xfer(5, 9, 12, 1'b0, 1'b1, 1'b1, 1'b0, 16'h01C3, 16'h02E7, 1'b0, "R6");
        // R1 R9 largest divider and delay
        run_xfer(255, 127, 9, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0155, 16'h00AA, 1'b0, "R1 R9");
        // R2 disabled divider codes
        try_disabled(1, 1'b1);
        try_disabled(0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule